// File: doc/BRIEF.md
# Accumulator ALU with Predicated Execution

This block is the arithmetic and logic stage of a small fractional signal-processing core. It holds a 24-bit accumulator and four status flags (carry, zero, negative, overflow). On each clock edge where execution is enabled and the selected condition holds, it combines the accumulator with one operand and writes back the result and the flags. Fourteen operations are supported: add, subtract, compare, AND, OR, XOR, absolute value, negate, increment, decrement, and four shifts and rotates.

The second operand comes from one of two sources. One is a full-width 24-bit operand. The other is a 16-bit data word, which is placed in the upper 16 bits with zeros below it. This follows the fractional convention of the core. A saturation enable clamps arithmetic results that leave the signed range. Decode, memories and pointer logic sit outside the block and present opcodes and operands on plain ports.

Top module: `acc_alu_core`

## Requirements
- R1: While rst_ni is low and after it is released, the accumulator is 000000h and the flags are Z=1, C=0, N=0, V=0.
- R2: With use_data_i=1 the operand is {data_i, 8'h00}, so the 16-bit word occupies bits 23:8. Example: adding data 0C12h to 123400h gives 1E4600h. With use_data_i=0 the operand is opnd_i.
- R3: For ADD (op 0), SUB (op 1) and CP (op 5), C is the carry out of the two's complement addition. For SUB and CP, C=1 means accumulator >= operand as unsigned numbers. V flags signed overflow. CP updates the flags from the difference and leaves the accumulator unchanged.
- R4: AND (op 2), OR (op 3) and XOR (op 4) write the bitwise result, clear V and keep C.
- R5: INC (op 8) and DEC (op 9) add +1 and -1. INC sets C when it wraps from FFFFFFh. DEC sets C when the accumulator was nonzero. V is set on 7FFFFFh+1 and on 800000h-1.
- R6: ABS (op 6) negates only a negative accumulator and always clears C. ABS of 800000h sets V and, without saturation, leaves 800000h with N=1.
- R7: NEG (op 7) writes 0 minus the accumulator, with C=1 only when the accumulator was zero. NEG of 000000h gives 000000h with Z=1, C=1, N=0, V=0. NEG of 800000h sets V.
- R8: SRA (op 10) shifts right and keeps bit 23, with bit 0 going to C; for example, 226A84h becomes 113542h. SLL (op 11) shifts left with zero fill, with bit 23 going to C. Both clear V.
- R9: RL (op 12) rotates left, copying bit 23 to bit 0 and to C. RR (op 13) rotates right, copying bit 0 to bit 23 and to C. Both clear V.
- R10: The condition code cond_i is tested against the flags as they were before the operation: 0 always, 1 Z, 2 NZ, 3 C, 4 NC, 5 N, 6 not N, 7 V, 8 not V, and 9 to 15 never. A false condition leaves the accumulator and all flags unchanged.
- R11: With sat_en_i=1, an ADD, SUB, INC, DEC, NEG or ABS whose true result is out of range sets V and writes 7FFFFFh when the true result is positive, or 800000h when it is negative.
- R12: With en_i=0, or with opcode 14 or 15, the accumulator and flags do not change.
- R13: After every executed operation other than CP, Z shows whether the accumulator is zero and N equals accumulator bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Execute the presented operation this cycle |
| op_i | input | 4 | Operation code |
| cond_i | input | 4 | Condition code |
| opnd_i | input | 24 | Full-width operand |
| data_i | input | 16 | 16-bit data operand, aligned to bits 23:8 |
| use_data_i | input | 1 | Select data_i instead of opnd_i |
| sat_en_i | input | 1 | Overflow protection (saturation) enable |
| acc_o | output | 24 | Accumulator |
| flag_c_o | output | 1 | Carry flag |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
Some properties hold on every cycle, and the assertions check these. An idle or never-true condition holds the state. A compare leaves the accumulator alone. Z and N track an unconditional result. A saturating arithmetic operation that overflows lands only on the two clamp values.

Other behaviour depends on exact values, and only the bench scenarios can show it. This covers the exact carry and overflow of every operation and the effect of the 16-bit alignment. It also covers the special cases of ABS and NEG at 800000h and 000000h, and each condition code passing or blocking against stored flags. The bench compares all of these against its own signed-integer model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_CP  = 4'd5,
    OP_ABS = 4'd6,
    OP_NEG = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_SRA = 4'd10,
    OP_SLL = 4'd11,
    OP_RL  = 4'd12,
    OP_RR  = 4'd13,
    OP_NP0 = 4'd14,
    OP_NP1 = 4'd15
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_ALW = 4'd0,
    CC_Z   = 4'd1,
    CC_NZ  = 4'd2,
    CC_C   = 4'd3,
    CC_NC  = 4'd4,
    CC_MI  = 4'd5,
    CC_PL  = 4'd6,
    CC_OV  = 4'd7,
    CC_NOV = 4'd8
  } cond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;

endpackage

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
  import acc_alu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       take_o
);

  always_comb begin
    unique case (cond_i)
      CC_ALW:  take_o = 1'b1;
      CC_Z:    take_o = flags_i.z;
      CC_NZ:   take_o = ~flags_i.z;
      CC_C:    take_o = flags_i.c;
      CC_NC:   take_o = ~flags_i.c;
      CC_MI:   take_o = flags_i.n;
      CC_PL:   take_o = ~flags_i.n;
      CC_OV:   take_o = flags_i.v;
      CC_NOV:  take_o = ~flags_i.v;
      default: take_o = 1'b0;  // reserved codes never execute
    endcase
  end

endmodule

// File: rtl/acc_alu_operand.sv
module acc_alu_operand #(
  parameter int ACC_W  = 24,
  parameter int DATA_W = 16
) (
  input  logic [ACC_W-1:0]  opnd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              use_data_i,
  output logic [ACC_W-1:0]  b_o
);

  localparam int PAD_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] data_al;

  generate
    if (PAD_W > 0) begin : g_pad
      assign data_al = {data_i, {PAD_W{1'b0}}};
    end else begin : g_flat
      assign data_al = data_i[DATA_W-1 -: ACC_W];
    end
  endgenerate

  assign b_o = use_data_i ? data_al : opnd_i;

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic [3:0]       op_i,
  input  logic [ACC_W-1:0] a_i,
  input  logic [ACC_W-1:0] b_i,
  input  logic             c_i,
  input  logic             sat_en_i,
  output logic [ACC_W-1:0] res_o,
  output flags_t           flags_o,
  output logic             wr_acc_o,
  output logic             wr_flags_o
);

  localparam int                 MSB  = ACC_W - 1;
  localparam logic [ACC_W-1:0]   MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]   MINV = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W:0]     ONE  = {{ACC_W{1'b0}}, 1'b1};

  logic [ACC_W:0] add_w, sub_w, neg_w, inc_w, dec_w;

  assign add_w = {1'b0, a_i} + {1'b0, b_i};
  assign sub_w = {1'b0, a_i} + {1'b0, ~b_i} + ONE;
  assign neg_w = {1'b0, ~a_i} + ONE;
  assign inc_w = {1'b0, a_i} + ONE;
  assign dec_w = {1'b0, a_i} + {1'b0, {ACC_W{1'b1}}};

  logic [ACC_W-1:0] raw;
  logic             c_nx, ovf, tneg, arith;

  always_comb begin
    raw        = a_i;
    c_nx       = c_i;
    ovf        = 1'b0;
    tneg       = 1'b0;
    arith      = 1'b0;
    wr_acc_o   = 1'b1;
    wr_flags_o = 1'b1;
    unique case (alu_op_e'(op_i))
      OP_ADD: begin
        raw   = add_w[MSB:0];
        c_nx  = add_w[ACC_W];
        ovf   = (a_i[MSB] == b_i[MSB]) && (add_w[MSB] != a_i[MSB]);
        tneg  = a_i[MSB];
        arith = 1'b1;
      end
      OP_SUB, OP_CP: begin
        raw      = sub_w[MSB:0];
        c_nx     = sub_w[ACC_W];
        ovf      = (a_i[MSB] != b_i[MSB]) && (sub_w[MSB] != a_i[MSB]);
        tneg     = a_i[MSB];
        arith    = (op_i == OP_SUB);
        wr_acc_o = (op_i == OP_SUB);
      end
      OP_AND: raw = a_i & b_i;
      OP_OR:  raw = a_i | b_i;
      OP_XOR: raw = a_i ^ b_i;
      OP_ABS: begin
        c_nx  = 1'b0;
        arith = 1'b1;
        if (a_i[MSB]) begin
          raw = neg_w[MSB:0];
          ovf = (a_i == MINV);
        end
      end
      OP_NEG: begin
        raw   = neg_w[MSB:0];
        c_nx  = neg_w[ACC_W];
        ovf   = (a_i == MINV);
        arith = 1'b1;
      end
      OP_INC: begin
        raw   = inc_w[MSB:0];
        c_nx  = inc_w[ACC_W];
        ovf   = (a_i == MAXV);
        arith = 1'b1;
      end
      OP_DEC: begin
        raw   = dec_w[MSB:0];
        c_nx  = dec_w[ACC_W];
        ovf   = (a_i == MINV);
        tneg  = 1'b1;
        arith = 1'b1;
      end
      OP_SRA: begin
        raw  = {a_i[MSB], a_i[MSB:1]};
        c_nx = a_i[0];
      end
      OP_SLL: begin
        raw  = {a_i[MSB-1:0], 1'b0};
        c_nx = a_i[MSB];
      end
      OP_RL: begin
        raw  = {a_i[MSB-1:0], a_i[MSB]};
        c_nx = a_i[MSB];
      end
      OP_RR: begin
        raw  = {a_i[0], a_i[MSB:1]};
        c_nx = a_i[0];
      end
      default: begin
        wr_acc_o   = 1'b0;
        wr_flags_o = 1'b0;
      end
    endcase
  end

  // clamp only arithmetic writes; compare reports the raw difference
  assign res_o     = (arith && ovf && sat_en_i) ? (tneg ? MINV : MAXV) : raw;
  assign flags_o.c = c_nx;
  assign flags_o.v = ovf;
  assign flags_o.z = (res_o == '0);
  assign flags_o.n = res_o[MSB];

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [3:0]        op_i,
  input  logic [3:0]        cond_i,
  input  logic [ACC_W-1:0]  opnd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              use_data_i,
  input  logic              sat_en_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              flag_c_o,
  output logic              flag_z_o,
  output logic              flag_n_o,
  output logic              flag_v_o
);

  logic [ACC_W-1:0] acc_q, b_op, res;
  flags_t           flg_q, flg_nx;
  logic             take, wr_acc, wr_flags, upd;

  acc_alu_operand #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_opnd (
    .opnd_i     (opnd_i),
    .data_i     (data_i),
    .use_data_i (use_data_i),
    .b_o        (b_op)
  );

  acc_alu_cond u_cond (
    .cond_i  (cond_i),
    .flags_i (flg_q),
    .take_o  (take)
  );

  acc_alu_exec #(.ACC_W(ACC_W)) u_exec (
    .op_i       (op_i),
    .a_i        (acc_q),
    .b_i        (b_op),
    .c_i        (flg_q.c),
    .sat_en_i   (sat_en_i),
    .res_o      (res),
    .flags_o    (flg_nx),
    .wr_acc_o   (wr_acc),
    .wr_flags_o (wr_flags)
  );

  assign upd = en_i && take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      flg_q <= '{c: 1'b0, z: 1'b1, n: 1'b0, v: 1'b0};
    end else begin
      if (upd && wr_acc)   acc_q <= res;
      if (upd && wr_flags) flg_q <= flg_nx;
    end
  end

  assign acc_o    = acc_q;
  assign flag_c_o = flg_q.c;
  assign flag_z_o = flg_q.z;
  assign flag_n_o = flg_q.n;
  assign flag_v_o = flg_q.v;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int ACC_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [3:0]       op_i,
  input logic [3:0]       cond_i,
  input logic             sat_en_i,
  input logic [ACC_W-1:0] acc_o,
  input logic             flag_c_o,
  input logic             flag_z_o,
  input logic             flag_n_o,
  input logic             flag_v_o
);

  localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic arith_op;
  assign arith_op = (op_i == 4'd0) || (op_i == 4'd1) || (op_i == 4'd6) ||
                    (op_i == 4'd7) || (op_i == 4'd8) || (op_i == 4'd9);

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o) && $stable(flag_c_o) && $stable(flag_z_o)
              && $stable(flag_n_o) && $stable(flag_v_o));

  // R3
  cp_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 4'd5) |=> $stable(acc_o));

  // R10
  never_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cond_i >= 4'd9) |=> $stable(acc_o) && $stable(flag_c_o)
                                  && $stable(flag_v_o));

  // R13
  zn_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cond_i == 4'd0 && op_i <= 4'd13 && op_i != 4'd5)
      |=> (flag_z_o == (acc_o == '0)) && (flag_n_o == acc_o[ACC_W-1]));

  // R11
  sat_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sat_en_i && cond_i == 4'd0 && arith_op)
      |=> (!flag_v_o || acc_o == MAXV || acc_o == MINV));

endmodule

bind acc_alu_core acc_alu_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .op_i     (op_i),
  .cond_i   (cond_i),
  .sat_en_i (sat_en_i),
  .acc_o    (acc_o),
  .flag_c_o (flag_c_o),
  .flag_z_o (flag_z_o),
  .flag_n_o (flag_n_o),
  .flag_v_o (flag_v_o)
);

// File: tb/acc_alu_core_bench.sv
module acc_alu_core_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [3:0]  op, cond;
  logic [23:0] opnd;
  logic [15:0] data;
  logic        use_d, sat;
  logic [23:0] acc;
  logic        fc, fz, fn, fv;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [23:0] m_acc;
  logic        m_c, m_z, m_n, m_v;

  always #5 clk = ~clk;

  acc_alu_core u_acc_alu_core (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .op_i (op), .cond_i (cond),
    .opnd_i (opnd), .data_i (data), .use_data_i (use_d), .sat_en_i (sat),
    .acc_o (acc), .flag_c_o (fc), .flag_z_o (fz), .flag_n_o (fn), .flag_v_o (fv)
  );

  function automatic bit cond_ok(input logic [3:0] cc);
    case (cc)
      4'd0: return 1'b1;
      4'd1: return m_z;
      4'd2: return !m_z;
      4'd3: return m_c;
      4'd4: return !m_c;
      4'd5: return m_n;
      4'd6: return !m_n;
      4'd7: return m_v;
      4'd8: return !m_v;
      default: return 1'b0;
    endcase
  endfunction

  // independent signed-integer reference
  task automatic model(input logic [3:0] o, input logic [3:0] cc,
                       input logic [23:0] b, input logic s, input logic e);
    longint sa, sb, t, ua, ub;
    logic [23:0] r;
    logic c, v;
    bit ar, wa;
    if (!e || !cond_ok(cc) || o > 4'd13) return;
    sa = longint'($signed(m_acc)); sb = longint'($signed(b));
    ua = longint'(m_acc); ub = longint'(b);
    ar = 0; wa = 1; c = m_c; v = 0; t = 0; r = m_acc;
    case (o)
      4'd0: begin t = sa + sb; c = (ua + ub) > 64'hFFFFFF; ar = 1; end
      4'd1: begin t = sa - sb; c = ua >= ub; ar = 1; end
      4'd5: begin t = sa - sb; c = ua >= ub; ar = 1; wa = 0; end
      4'd2: r = m_acc & b;
      4'd3: r = m_acc | b;
      4'd4: r = m_acc ^ b;
      4'd6: begin t = (sa < 0) ? -sa : sa; c = 0; ar = 1; end
      4'd7: begin t = -sa; c = (ua == 0); ar = 1; end
      4'd8: begin t = sa + 1; c = (ua == 64'hFFFFFF); ar = 1; end
      4'd9: begin t = sa - 1; c = (ua != 0); ar = 1; end
      4'd10: begin r = {m_acc[23], m_acc[23:1]}; c = m_acc[0]; end
      4'd11: begin r = {m_acc[22:0], 1'b0}; c = m_acc[23]; end
      4'd12: begin r = {m_acc[22:0], m_acc[23]}; c = m_acc[23]; end
      default: begin r = {m_acc[0], m_acc[23:1]}; c = m_acc[0]; end
    endcase
    if (ar) begin
      v = (t > 64'sd8388607) || (t < -64'sd8388608);
      if (v && s && o != 4'd5) r = (t > 0) ? 24'h7FFFFF : 24'h800000;
      else r = t[23:0];
    end
    m_c = c; m_v = v; m_z = (r == 0); m_n = r[23];
    if (wa) m_acc = r;
  endtask

  task automatic vec(input logic [3:0] o, input logic [3:0] cc,
                     input logic [23:0] ob, input logic [15:0] d,
                     input logic ud, input logic s, input logic e,
                     input string tag);
    op = o; cond = cc; opnd = ob; data = d; use_d = ud; sat = s; en = e;
    model(o, cc, ud ? {d, 8'h00} : ob, s, e);
    @(negedge clk);
    en = 1'b0;
    n_chk++;
    if (acc !== m_acc || fc !== m_c || fz !== m_z || fn !== m_n || fv !== m_v) begin
      n_bad++;
      $display("FAIL %s op=%0d cc=%0d: acc=%h czn v=%b%b%b%b, expected acc=%h czn v=%b%b%b%b",
               tag, o, cc, acc, fc, fz, fn, fv, m_acc, m_c, m_z, m_n, m_v);
    end
  endtask

  task automatic expect_val(input string tag, input logic [27:0] got, input logic [27:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [23:0] val, input string tag);
    vec(4'd2, 4'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, tag);
    vec(4'd3, 4'd0, val, 16'h0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; en = 1'b0; op = '0; cond = '0; opnd = '0; data = '0;
    use_d = 1'b0; sat = 1'b0;
    m_acc = '0; m_c = 0; m_z = 1; m_n = 0; m_v = 0;
    repeat (3) @(negedge clk);
    expect_val("R1 reset in", {acc, fc, fz, fn, fv}, {24'h0, 4'b0100});
    rst_n = 1'b1;
    @(negedge clk);
    expect_val("R1 reset out", {acc, fc, fz, fn, fv}, {24'h0, 4'b0100});

    // R2 data alignment
    load(24'h123400, "R2 load");
    vec(4'd0, 4'd0, 24'h0, 16'h0C12, 1'b1, 1'b0, 1'b1, "R2 add data");
    expect_val("R2 add value", {acc, 4'h0}, {24'h1E4600, 4'h0});
    // R3 compare keeps acc
    vec(4'd5, 4'd0, 24'h1E4600, 16'h0, 1'b0, 1'b0, 1'b1, "R3 cp equal");
    expect_val("R3 cp flags", {acc, fc, fz, fn, fv}, {24'h1E4600, 4'b1100});
    // R4 logic keeps carry
    vec(4'd4, 4'd0, 24'hFFFFFF, 16'h0, 1'b0, 1'b0, 1'b1, "R4 xor");
    // R6 ABS of most negative
    load(24'h800000, "R6 load");
    vec(4'd6, 4'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, "R6 abs min");
    expect_val("R6 abs min flags", {acc, fc, fz, fn, fv}, {24'h800000, 4'b0011});
    vec(4'd6, 4'd0, 24'h0, 16'h0, 1'b0, 1'b1, 1'b1, "R11 abs min sat");
    expect_val("R11 abs sat value", {acc, 4'h0}, {24'h7FFFFF, 4'h0});
    // R7 NEG of zero
    load(24'h000000, "R7 load");
    vec(4'd7, 4'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, "R7 neg zero");
    expect_val("R7 neg zero flags", {acc, fc, fz, fn, fv}, {24'h0, 4'b1100});
    // R10 DEC MI on positive does nothing
    load(24'h7A2500, "R10 load");
    vec(4'd9, 4'd5, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, "R10 dec mi");
    expect_val("R10 dec mi value", {acc, 4'h0}, {24'h7A2500, 4'h0});
    // R8 SRA example
    load(24'h226A84, "R8 load");
    vec(4'd10, 4'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, "R8 sra");
    expect_val("R8 sra value", {acc, 4'h0}, {24'h113542, 4'h0});
    vec(4'd11, 4'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, "R8 sll");
    // R9 rotates
    load(24'h800001, "R9 load");
    vec(4'd12, 4'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, "R9 rl");
    vec(4'd13, 4'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, "R9 rr");
    // R5 and R11 boundaries
    load(24'h7FFFFF, "R5 load max");
    vec(4'd8, 4'd0, 24'h0, 16'h0, 1'b0, 1'b1, 1'b1, "R11 inc max sat");
    expect_val("R11 inc sat value", {acc, fv}, {24'h7FFFFF, 1'b1});
    vec(4'd8, 4'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, "R5 inc max wrap");
    vec(4'd9, 4'd0, 24'h0, 16'h0, 1'b0, 1'b1, 1'b1, "R5 dec min sat");
    load(24'hFFFFFF, "R5 load ones");
    vec(4'd8, 4'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, "R5 inc wrap carry");
    load(24'h800000, "R11 load min");
    vec(4'd1, 4'd0, 24'h000001, 16'h0, 1'b0, 1'b1, 1'b1, "R11 sub min sat");
    vec(4'd0, 4'd0, 24'h7FFFFF, 16'h0, 1'b0, 1'b1, 1'b1, "R11 add sat");
    vec(4'd7, 4'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b1, "R7 neg");
    // R12 idle and reserved opcodes
    vec(4'd0, 4'd0, 24'h111111, 16'h0, 1'b0, 1'b0, 1'b0, "R12 en low");
    vec(4'd14, 4'd0, 24'h111111, 16'h0, 1'b0, 1'b0, 1'b1, "R12 op14");
    vec(4'd15, 4'd0, 24'h111111, 16'h0, 1'b0, 1'b0, 1'b1, "R12 op15");
    vec(4'd0, 4'd12, 24'h111111, 16'h0, 1'b0, 1'b0, 1'b1, "R10 never");

    // random mix (R3..R13)
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  o, cc;
      logic [23:0] ob;
      int sel;
      o  = 4'($urandom_range(0, 15));
      cc = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
      sel = $urandom_range(0, 5);
      case (sel)
        0: ob = 24'h7FFFFF;
        1: ob = 24'h800000;
        2: ob = 24'h000000;
        default: ob = 24'($urandom);
      endcase
      if ($urandom_range(0, 30) == 0) load(ob, "R13 rand load");
      vec(o, cc, ob, 16'($urandom), 1'($urandom), 1'($urandom),
          ($urandom_range(0, 9) != 0), "R13 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule